// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address stream for a single read or write burst in a synchronous DRAM controller. A start strobe loads a start column together with a 3-bit length code and a one-bit ordering select. From then on the block emits one column address per clock with a valid flag. A done pulse marks the final beat. The block decodes the length and ordering codes itself. Fixed-length bursts stay inside an aligned block whose size is the burst length. Full-page bursts walk the whole row and keep going until a stop strobe arrives.

The downstream command and data path uses the address stream, the valid flag and the done pulse to drive column accesses. A new start strobe may arrive while a burst is running. It abandons the running burst and begins the new one in the same clock. A stop strobe ends the stream. An illegal code combination falls back to a single-beat burst and raises an error flag, so a bad configuration never produces a runaway sequence.

Top module: `burst_col_gen`

## Requirements
- R1: The length code sets the number of valid beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 with sequential ordering gives a full-page burst. After the last beat of a fixed-length burst, `col_valid` is low.
- R2: When `mode_order` = 0 (sequential), beat k carries the start column with its low log2(BL) bits replaced by (start low bits + k) mod BL. The upper bits stay equal to those of the start column. Example: start 5, BL 8 gives 5,6,7,0,1,2,3,4.
- R3: When `mode_order` = 1 (interleave), beat k carries the start column with its low log2(BL) bits XORed with k. Example: start 5, BL 8 gives 5,4,7,6,1,0,3,2.
- R4: A full-page burst emits start, start+1, … modulo 2^COL_W, so it wraps from 255 to 0. It never raises `burst_done`.
- R5: `burst_done` is high only together with `col_valid`, on the final beat of a fixed-length burst. For length 1, valid and done both appear on the single beat.
- R6: A `burst_stop` sampled at a clock edge, with no start at that edge, leaves `col_valid` and `burst_done` low from that edge on.
- R7: A `burst_start` during a running burst replaces it at that edge. The next beat is the new start column, and the sequence follows the newly latched length and ordering.
- R8: The length codes 3'b100, 3'b101 and 3'b110, and 3'b111 together with interleave ordering, are reserved. They produce a single beat with done, and `mode_err` = 1 until the next start. A legal code at the next start returns `mode_err` to 0.
- R9: A synchronous active-high `rst` drives `col_valid`, `burst_done` and `mode_err` low at the next edge. It also abandons any burst in progress.
- R10: The first beat appears at the clock edge that samples `burst_start`. The following beats appear on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_len | input | 3 | Burst length code, latched on start |
| mode_order | input | 1 | Ordering select, latched on start: 0 sequential, 1 interleave |
| burst_start | input | 1 | Start (or restart) strobe for a burst |
| burst_stop | input | 1 | Stop strobe, ends the running burst |
| start_col | input | COL_W (8) | Start column address |
| col_addr | output | COL_W (8) | Column address of the current beat |
| col_valid | output | 1 | Current beat is valid |
| burst_done | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Reserved code latched by the last start |

## Verification
The bench builds the block with its default 8-bit column. It sweeps every start column against all sixteen combinations of length code and ordering, except full-page sequential. That sweep covers each aligned block boundary, every interleave pattern and every reserved code. Full-page runs start at columns near 0 and near 255 and run past 256 beats, so the wrap and the stop path are both exercised. Directed sequences add a restart in mid-burst with a change of ordering, and resets in mid-burst and after an error.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int unsigned LEN_CODE_W = 3;
  localparam int unsigned FIX_LG_W   = 2;   // log2 of the largest fixed length (8) fits here

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef struct packed {
    logic                full;   // run the whole row until stopped
    logic [FIX_LG_W-1:0] lg;     // log2 of fixed burst length
    order_e              order;
    logic                err;    // reserved code seen
  } burst_cfg_t;

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import burst_col_pkg::*;
(
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  order_sel,
  output burst_cfg_t            cfg
);

  always_comb begin
    cfg.full  = 1'b0;
    cfg.lg    = '0;
    cfg.order = order_e'(order_sel);
    cfg.err   = 1'b0;
    unique case (len_code)
      3'b000: cfg.lg = 2'd0;
      3'b001: cfg.lg = 2'd1;
      3'b010: cfg.lg = 2'd2;
      3'b011: cfg.lg = 2'd3;
      3'b111: begin
        if (order_sel == 1'b0) cfg.full = 1'b1;
        else                   cfg.err  = 1'b1;
      end
      default: cfg.err = 1'b1;
    endcase
  end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0]    base,
  input  logic [COL_W-1:0]    beat,
  input  logic                full,
  input  logic [FIX_LG_W-1:0] lg,
  input  order_e              order,
  output logic [COL_W-1:0]    addr
);

  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] mask;

  assign sum = base + beat;

  // Each address bit is either held from the base (outside the wrap block)
  // or taken from the counted / XORed value (inside it).
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign mask[i] = full | (32'(lg) > i);
    assign addr[i] = !mask[i]         ? base[i] :
                     (order == ORD_ILV) ? (base[i] ^ beat[i]) :
                                          sum[i];
  end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  burst_cfg_t       cfg_in,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic             cfg_err
);

  logic             active;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] next_addr;
  logic [COL_W-1:0] last_idx;
  logic             at_end;
  logic             single;

  burst_addr_map #(.COL_W(COL_W)) map_i (
    .base  (base_q),
    .beat  (beat_q),
    .full  (cfg_q.full),
    .lg    (cfg_q.lg),
    .order (cfg_q.order),
    .addr  (next_addr)
  );

  assign last_idx = (COL_W'(1) << cfg_q.lg) - COL_W'(1);
  assign at_end   = !cfg_q.full && (beat_q == last_idx);
  assign single   = !cfg_in.full && (cfg_in.lg == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      base_q    <= '0;
      beat_q    <= '0;
      cfg_q     <= '0;
      col_addr  <= '0;
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      cfg_err   <= 1'b0;
    end else if (start) begin
      base_q    <= start_col;
      cfg_q     <= cfg_in;
      beat_q    <= COL_W'(1);
      col_addr  <= start_col;
      col_valid <= 1'b1;
      col_last  <= single;
      cfg_err   <= cfg_in.err;
      active    <= !single;
    end else if (stop) begin
      active    <= 1'b0;
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end else if (active) begin
      col_addr  <= next_addr;
      col_valid <= 1'b1;
      col_last  <= at_end;
      beat_q    <= beat_q + COL_W'(1);
      active    <= !at_end;
    end else begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end
  end

  // R5: the final-beat marker never stands alone
  a_r5_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  // R4: a full-page burst has no final beat
  a_r4_full_no_done: assert property (@(posedge clk) disable iff (rst)
    (col_valid && cfg_q.full) |-> !col_last);

  // R2: bits above the largest fixed block never move inside a fixed burst
  a_r2_block_fixed: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_last && !cfg_q.full && !start && !stop)
      |=> $stable(col_addr[COL_W-1:3]));

  // R10: a running burst with no strobe produces the next beat on the next edge
  a_r10_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_last && !stop) |=> col_valid);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LEN_CODE_W-1:0] mode_len,
  input  logic                  mode_order,
  input  logic                  burst_start,
  input  logic                  burst_stop,
  input  logic [COL_W-1:0]      start_col,
  output logic [COL_W-1:0]      col_addr,
  output logic                  col_valid,
  output logic                  burst_done,
  output logic                  mode_err
);

  burst_cfg_t dec_cfg;

  burst_mode_decode dec_i (
    .len_code  (mode_len),
    .order_sel (mode_order),
    .cfg       (dec_cfg)
  );

  burst_seq_ctrl #(.COL_W(COL_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (burst_start),
    .stop      (burst_stop),
    .start_col (start_col),
    .cfg_in    (dec_cfg),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .col_last  (burst_done),
    .cfg_err   (mode_err)
  );

  // R10: start produces its first beat, carrying the start column
  a_r10_first_beat: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> (col_valid && col_addr == $past(start_col)));

  // R5: a single-beat burst is valid and done at once
  a_r5_single_beat: assert property (@(posedge clk) disable iff (rst)
    (burst_start && !dec_cfg.full && dec_cfg.lg == '0) |=> (col_valid && burst_done));

  // R6: stop without start silences the stream
  a_r6_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    (burst_stop && !burst_start) |=> (!col_valid && !burst_done));

  // R8: reserved code gives a flagged single beat
  a_r8_reserved: assert property (@(posedge clk) disable iff (rst)
    (burst_start && dec_cfg.err) |=> (mode_err && burst_done));

  // R9: reset clears the outputs
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!col_valid && !burst_done && !mode_err));

endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       mode_len = '0;
  logic             mode_order = 1'b0;
  logic             burst_start = 1'b0;
  logic             burst_stop = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [COL_W-1:0] col_addr;
  logic             col_valid;
  logic             burst_done;
  logic             mode_err;

  int nchk  = 0;
  int nfail = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk, .rst, .mode_len, .mode_order, .burst_start, .burst_stop,
    .start_col, .col_addr, .col_valid, .burst_done, .mode_err
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_full(int code, int typ);
    return (code == 7 && typ == 0);
  endfunction

  function automatic bit is_res(int code, int typ);
    return !(code <= 3 || is_full(code, typ));
  endfunction

  function automatic int blen(int code, int typ);
    if (is_full(code, typ)) return PAGE;
    if (code <= 3) return 1 << code;
    return 1;
  endfunction

  function automatic int exp_addr(int code, int typ, int col, int k);
    int bl, blk, off;
    if (is_full(code, typ)) return (col + k) % PAGE;
    bl  = blen(code, typ);
    off = col % bl;
    blk = col - off;
    if (typ != 0) return blk + (off ^ k);
    return blk + ((off + k) % bl);
  endfunction

  task automatic do_start(int code, int typ, int col);
    mode_len    = 3'(code);
    mode_order  = typ[0];
    start_col   = COL_W'(col);
    burst_start = 1'b1;
  endtask

  // check beat k of a burst; outputs sampled at the falling edge
  task automatic chk_beat(int code, int typ, int col, int k, int n);
    bit full = is_full(code, typ);
    int e = exp_addr(code, typ, col, k);
    string at = full ? "R4" : (typ != 0 ? "R3" : "R2");
    chk(col_valid == 1'b1, "R1/R10 valid", int'(col_valid), 1);
    chk(int'(col_addr) == e, at, int'(col_addr), e);
    chk(burst_done == (!full && k == n - 1), "R5 done",
        int'(burst_done), int'(!full && k == n - 1));
    chk(mode_err == is_res(code, typ), "R8 err", int'(mode_err), int'(is_res(code, typ)));
  endtask

  task automatic run_burst(int code, int typ, int col, int fp_beats);
    bit full = is_full(code, typ);
    int n = full ? fp_beats : blen(code, typ);
    @(negedge clk);
    do_start(code, typ, col);
    @(negedge clk);
    burst_start = 1'b0;
    mode_len    = 3'(code ^ 5);   // latched copy must be used
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      chk_beat(code, typ, col, k, n);
    end
    if (full) burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk(col_valid == 1'b0, full ? "R6 stop" : "R1 end", int'(col_valid), 0);
    chk(burst_done == 1'b0, full ? "R6 stop" : "R5 end", int'(burst_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(col_valid == 1'b0, "R9 reset", int'(col_valid), 0);
    chk(burst_done == 1'b0, "R9 reset", int'(burst_done), 0);
    chk(mode_err == 1'b0, "R9 reset", int'(mode_err), 0);
    rst = 1'b0;

    // exhaustive fixed / reserved sweep (R1, R2, R3, R5, R8)
    for (int code = 0; code < 8; code++)
      for (int typ = 0; typ < 2; typ++)
        if (!is_full(code, typ))
          for (int col = 0; col < PAGE; col++)
            run_burst(code, typ, col, 0);

    // full page with wrap and stop (R4, R6)
    run_burst(7, 0, 0, PAGE + 4);
    run_burst(7, 0, 3, PAGE + 1);
    run_burst(7, 0, 250, 20);

    // restart in mid-burst with new length and ordering (R7)
    @(negedge clk);
    do_start(3, 0, 5);
    @(negedge clk);
    burst_start = 1'b0;
    chk_beat(3, 0, 5, 0, 8);
    @(negedge clk);
    chk_beat(3, 0, 5, 1, 8);
    do_start(2, 1, 66);
    @(negedge clk);
    burst_start = 1'b0;
    chk(int'(col_addr) == 66, "R7 restart", int'(col_addr), 66);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      chk_beat(2, 1, 66, k, 4);
    end
    @(negedge clk);
    chk(col_valid == 1'b0, "R7 end", int'(col_valid), 0);

    // reserved code then reset clears the flag (R8, R9)
    run_burst(5, 0, 9, 0);
    chk(mode_err == 1'b1, "R8 held", int'(mode_err), 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(mode_err == 1'b0, "R9 err", int'(mode_err), 0);

    // reset in mid-burst (R9)
    @(negedge clk);
    do_start(3, 0, 0);
    @(negedge clk);
    burst_start = 1'b0;
    chk_beat(3, 0, 0, 0, 8);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(col_valid == 1'b0, "R9 abort", int'(col_valid), 0);
    @(negedge clk);
    chk(col_valid == 1'b0, "R9 abort", int'(col_valid), 0);

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule